// File: doc/BRIEF.md
# Emergency Shutdown Request Input Filter

This block watches three active-low external shutdown request pins and raises one sticky flag per pin when a qualifying request arrives. Each pin is first brought into the clock domain by a two-stage synchronizer. A 2-bit mode field per pin selects the detection method. One method reacts to a single falling edge. The other requires sixteen consecutive low samples, taken at one of three prescaled rates derived from the block clock. The three rates are divide-by-8, divide-by-16 and divide-by-128, and all three come from one shared free-running prescaler.

Software programs the mode fields through a configuration register. That register accepts only the first write after reset. A raised flag stays set until software clears it. To clear a flag, software must first read the flags while that flag is 1, and then write 0 to that bit. The OR of all flags drives a combined shutdown output. After a flag has been cleared it does not return until a new qualifying event occurs. For the edge mode the new event is another falling edge. For the filter modes it is a high sample followed by a new run of sixteen low samples.

Top module: `shutdown_req_filter`

## Requirements
- R1: After reset, `flags_o` is 0, `mode_o` is 0 and `shutdown_o` is 0.
- R2: In mode 00, a falling edge on a request pin sets that pin's flag within 5 clock cycles.
- R3: In mode 01, a pin that is held low sets its flag once 16 consecutive low samples have been taken at clk/8. This happens within 140 cycles of the pin falling. A low pulse of 100 cycles or less followed by a high level sets nothing.
- R4: In mode 10, the same 16-sample rule applies with samples at clk/16. A pin held low sets its flag within 280 cycles. A low time of 200 cycles sets nothing.
- R5: In mode 11, the same 16-sample rule applies with samples at clk/128. A pin held low sets its flag within 2200 cycles. A low time of 1900 cycles sets nothing.
- R6: Only the first `cfg_we_i` write after reset loads the mode register. Every later write leaves `mode_o` unchanged.
- R7: A flag bit clears only when `flag_we_i` writes 0 to it and an earlier `flag_rd_i` strobe saw that bit as 1. Writing 1 to a flag does nothing. A write without a prior read does nothing. Each flag write uses up the read that allowed it.
- R8: A set flag stays set until it is cleared. After it is cleared, a pin that stays low does not set it again.
- R9: `shutdown_o` is 1 exactly when at least one flag is 1.
- R10: Mode field placement is as follows: pin 0 uses bits [1:0], pin 1 uses [3:2] and pin 2 uses [5:4]. Flag bit i belongs to pin i, and the pins are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the prescaler divides this clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n_i | input | 3 | Active-low shutdown request pins |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | 6 | Mode register write data |
| mode_o | output | 6 | Current mode register contents |
| flag_rd_i | input | 1 | Flag register read strobe |
| flag_we_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 3 | Flag register write data |
| flags_o | output | 3 | Sticky request flags |
| shutdown_o | output | 1 | OR of all flags |

## Verification
The main risk is a bad low-sample counter or a bad prescaler tick, so the checks look at timing. Either fault shifts the moment a flag rises in filter mode, and the shift is visible within one sample window. Each window is timed so that it can only pass when the design meets the requirement. A lost read-arm bit or a failed lock of the mode register shows up on `flags_o` or `mode_o` in the cycle after the register access. A counter that does not saturate shows up as a flag that sets again while the pin is still held low.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    typedef enum logic [1:0] {
        MODE_EDGE  = 2'b00,
        MODE_SLOW1 = 2'b01,
        MODE_SLOW2 = 2'b10,
        MODE_SLOW3 = 2'b11
    } sdr_mode_e;
endpackage

// File: rtl/sdr_prescaler.sv
module sdr_prescaler #(
    parameter int DIV_A = 8,
    parameter int DIV_B = 16,
    parameter int DIV_C = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] tick_o
);
    localparam int CW = $clog2(DIV_C);
    localparam int WA = $clog2(DIV_A);
    localparam int WB = $clog2(DIV_B);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o[0] = &st_q.cnt[WA-1:0];
    assign tick_o[1] = &st_q.cnt[WB-1:0];
    assign tick_o[2] = &st_q.cnt;
endmodule

// File: rtl/sdr_channel.sv
module sdr_channel
    import sdr_pkg::*;
#(
    parameter int SAMPLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_n_i,
    input  sdr_mode_e  mode_i,
    input  logic [2:0] tick_i,
    output logic       fire_o
);
    localparam int CNTW = $clog2(SAMPLES + 1);

    typedef struct packed {
        logic            meta;
        logic            sync;
        logic            prev;
        logic [CNTW-1:0] cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      tick_sel;
    logic      fall;

    always_comb begin
        st_d      = st_q;
        st_d.meta = req_n_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        fall      = st_q.prev & ~st_q.sync;
        fire_o    = 1'b0;
        case (mode_i)
            MODE_SLOW1: tick_sel = tick_i[0];
            MODE_SLOW2: tick_sel = tick_i[1];
            MODE_SLOW3: tick_sel = tick_i[2];
            default:    tick_sel = 1'b0;
        endcase
        if (mode_i == MODE_EDGE) begin
            st_d.cnt = '0;
            fire_o   = fall;
        end else if (tick_sel) begin
            if (st_q.sync) begin
                st_d.cnt = '0;
            end else begin
                if (st_q.cnt != CNTW'(SAMPLES)) st_d.cnt = st_q.cnt + 1'b1;
                fire_o = (st_q.cnt == CNTW'(SAMPLES - 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.meta <= 1'b1;
            st_q.sync <= 1'b1;
            st_q.prev <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/shutdown_req_filter.sv
module shutdown_req_filter
    import sdr_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int SAMPLES = 16,
    parameter int DIV_A   = 8,
    parameter int DIV_B   = 16,
    parameter int DIV_C   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req_n_i,
    input  logic              cfg_we_i,
    input  logic [2*NCH-1:0]  cfg_wdata_i,
    output logic [2*NCH-1:0]  mode_o,
    input  logic              flag_rd_i,
    input  logic              flag_we_i,
    input  logic [NCH-1:0]    flag_wdata_i,
    output logic [NCH-1:0]    flags_o,
    output logic              shutdown_o
);
    localparam int MW = 2 * NCH;

    typedef struct packed {
        logic [MW-1:0]  mode;
        logic           locked;
        logic [NCH-1:0] flags;
        logic [NCH-1:0] armed;
    } top_state_t;

    top_state_t     st_d, st_q;
    logic [2:0]     tick;
    logic [NCH-1:0] fire;

    sdr_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        sdr_channel #(.SAMPLES(SAMPLES)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_n_i (req_n_i[i]),
            .mode_i  (sdr_mode_e'(st_q.mode[2*i +: 2])),
            .tick_i  (tick),
            .fire_o  (fire[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (cfg_we_i && !st_q.locked) begin
            st_d.mode   = cfg_wdata_i;
            st_d.locked = 1'b1;
        end
        if (flag_we_i) begin
            st_d.flags = st_q.flags & ~(st_q.armed & ~flag_wdata_i);
            st_d.armed = '0;
        end else if (flag_rd_i) begin
            st_d.armed = st_q.armed | st_q.flags;
        end
        st_d.flags = st_d.flags | fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o     = st_q.mode;
    assign flags_o    = st_q.flags;
    assign shutdown_o = |st_q.flags;
endmodule

// File: rtl/sdr_checker.sv
module sdr_checker #(
    parameter int NCH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   req_n_i,
    input logic             cfg_we_i,
    input logic [2*NCH-1:0] mode_o,
    input logic             flag_we_i,
    input logic [NCH-1:0]   flags_o
);
    logic wrote_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wrote_q <= 1'b0;
        else if (cfg_we_i) wrote_q <= 1'b1;
    end

    // R6: once a write has landed, the mode never moves again
    p_mode_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrote_q |=> $stable(mode_o));

    // R6: mode changes only right after a write strobe
    p_mode_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> $past(cfg_we_i));

    // R8: with no flag write, no set flag drops
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R7: a flag only falls following a flag write
    p_clear_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags_o & $past(flags_o)) != '0) |-> $past(flag_we_i));

    // R2: a flag only rises when its pin was low two cycles earlier
    p_set_needs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & ~$past(flags_o) & $past(req_n_i, 2)) == '0));
endmodule

bind shutdown_req_filter sdr_checker #(.NCH(NCH)) u_chk (.*);

// File: tb/shutdown_req_filter_bench.sv
`timescale 1ns/1ps
module shutdown_req_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_n_i = 3'b111;
    logic       cfg_we_i = 1'b0;
    logic [5:0] cfg_wdata_i = '0;
    logic [5:0] mode_o;
    logic       flag_rd_i = 1'b0;
    logic       flag_we_i = 1'b0;
    logic [2:0] flag_wdata_i = '0;
    logic [2:0] flags_o;
    logic       shutdown_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    shutdown_req_filter u_shutdown_req_filter (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_n_i = 3'b111;
        cfg_we_i = 0; flag_rd_i = 0; flag_we_i = 0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic cfg_write(logic [5:0] d);
        @(negedge clk); cfg_we_i = 1'b1; cfg_wdata_i = d;
        @(negedge clk); cfg_we_i = 1'b0;
        wait_cyc(1);
    endtask

    task automatic flag_read();
        @(negedge clk); flag_rd_i = 1'b1;
        @(negedge clk); flag_rd_i = 1'b0;
    endtask

    task automatic flag_write(logic [2:0] d);
        @(negedge clk); flag_we_i = 1'b1; flag_wdata_i = d;
        @(negedge clk); flag_we_i = 1'b0;
        wait_cyc(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 flags", 8'(flags_o), 8'h0);
        chk("R1 mode", 8'(mode_o), 8'h0);
        chk("R1 shutdown", 8'(shutdown_o), 8'h0);
    endtask

    task automatic t_edge_and_clear();
        do_reset();
        @(negedge clk); req_n_i[0] = 1'b0;
        wait_cyc(5);
        chk("R2 edge sets flag0", 8'(flags_o), 8'h1);
        chk("R9 shutdown on", 8'(shutdown_o), 8'h1);
        flag_write(3'b000);
        chk("R7 write0 without read ignored", 8'(flags_o), 8'h1);
        flag_read();
        flag_write(3'b111);
        chk("R7 write1 ignored", 8'(flags_o), 8'h1);
        flag_read();
        flag_write(3'b000);
        chk("R7 read then write0 clears", 8'(flags_o), 8'h0);
        chk("R9 shutdown off", 8'(shutdown_o), 8'h0);
        wait_cyc(20);
        chk("R8 held low no reset", 8'(flags_o), 8'h0);
        @(negedge clk); req_n_i[0] = 1'b1;
        wait_cyc(4);
        @(negedge clk); req_n_i[0] = 1'b0;
        wait_cyc(5);
        chk("R2 fresh edge sets again", 8'(flags_o), 8'h1);
        @(negedge clk); req_n_i[2] = 1'b0;
        wait_cyc(5);
        chk("R10 pin2 maps to flag2", 8'(flags_o), 8'h5);
        wait_cyc(10);
        chk("R8 flags sticky", 8'(flags_o), 8'h5);
    endtask

    task automatic t_div8_lock();
        do_reset();
        cfg_write(6'b00_00_01);
        chk("R10 mode field pin0", 8'(mode_o), 8'h01);
        cfg_write(6'b11_11_11);
        chk("R6 second write ignored", 8'(mode_o), 8'h01);
        @(negedge clk); req_n_i[0] = 1'b0;
        wait_cyc(100);
        req_n_i[0] = 1'b1;
        wait_cyc(20);
        chk("R3 short low ignored", 8'(flags_o), 8'h0);
        req_n_i[0] = 1'b0;
        wait_cyc(140);
        chk("R3 16 samples at div8 set flag0", 8'(flags_o), 8'h1);
        flag_read();
        flag_write(3'b110);
        chk("R7 clear filter flag", 8'(flags_o), 8'h0);
        wait_cyc(200);
        chk("R8 filter needs fresh run", 8'(flags_o), 8'h0);
        @(negedge clk); req_n_i[1] = 1'b0;
        wait_cyc(5);
        chk("R10 pin1 still edge mode", 8'(flags_o), 8'h2);
    endtask

    task automatic t_div16_div128();
        do_reset();
        cfg_write(6'b11_10_00);
        chk("R10 mode fields pin1 pin2", 8'(mode_o), 8'h38);
        @(negedge clk); req_n_i[1] = 1'b0;
        wait_cyc(200);
        req_n_i[1] = 1'b1;
        wait_cyc(40);
        chk("R4 200-cycle low ignored", 8'(flags_o), 8'h0);
        req_n_i[1] = 1'b0;
        wait_cyc(280);
        chk("R4 div16 sets flag1", 8'(flags_o), 8'h2);
        @(negedge clk); req_n_i[2] = 1'b0;
        wait_cyc(300);
        chk("R5 not set at div16 timing", 8'(flags_o), 8'h2);
        wait_cyc(1600);
        req_n_i[2] = 1'b1;
        wait_cyc(300);
        chk("R5 1900-cycle low ignored", 8'(flags_o), 8'h2);
        req_n_i[2] = 1'b0;
        wait_cyc(2200);
        chk("R5 div128 sets flag2", 8'(flags_o), 8'h6);
    endtask

    initial begin
        #2000000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_edge_and_clear();
        t_div8_lock();
        t_div16_div128();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule